// File: doc/BRIEF.md
# Translation Context Quadrant Selector

This block sits in front of a radix-mode address translation path. Each memory access brings a 64-bit effective address, the two privilege bits (hypervisor state and problem state) and the current logical-partition and process identifier register values. The block returns the translation context that the walker must use: an effective partition identifier, an effective process identifier, a flag that asks for the second, partition-scoped stage, and a fault flag for an address region that may not be touched in the current privilege state.

The top two address bits split the address space into four regions. In hypervisor state, region 0 and region 3 translate the host's own spaces under partition 0. Regions 1 and 2 let privileged hypervisor code reach the user and kernel spaces of the guest currently loaded in the registers, with no register reload. A guest sees region 0 as its applications and region 3 as its kernel, and both always pass through its own partition-scoped tree.

Requests and results move over a valid/ready handshake. Each result is registered one cycle after it is accepted and is held for as long as the consumer stalls.

Top module: `qsel_ctx_select`

## Requirements
- R1: The region is in_ea[63:62] (0 to 3). No other address bit changes any result.
- R2: With hv=1 and region 0, the result is partition 0 and the process register value, with stage-two clear and no fault.
- R3: Region 3 always gives process 0. With hv=1 it gives partition 0 and stage-two clear, and this holds for pr either 0 or 1.
- R4: With hv=1, pr=0 and region 1, the result is the partition register and the process register. Stage-two is set exactly when the partition register is non-zero.
- R5: With hv=1, pr=0 and region 2, the result is the partition register and process 0. Stage-two is set exactly when the partition register is non-zero.
- R6: With hv=0, region 0 gives the partition register and the process register, and region 3 gives the partition register and process 0. In both cases stage-two is set.
- R7: Regions 1 and 2 fault when hv=0 or pr=1. A faulting result carries partition 0, process 0 and stage-two clear.
- R8: A request accepted on a clock edge (in_valid and in_ready both high) shows its result with out_valid high after that edge. in_ready is high whenever out_valid is low or out_ready is high.
- R9: While out_valid is high and out_ready is low, every output holds steady and in_ready is low. After a handshake with no new request, out_valid goes low.
- R10: Out of reset (synchronous, active high), out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request may be accepted |
| in_ea | input | 64 | Effective address |
| in_hv | input | 1 | Hypervisor state bit |
| in_pr | input | 1 | Problem (user) state bit |
| in_lpid | input | LPID_W | Current partition identifier register |
| in_pid | input | PID_W | Current process identifier register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_lpid | output | LPID_W | Effective partition identifier |
| out_pid | output | PID_W | Effective process identifier |
| out_stage2 | output | 1 | Partition-scoped second stage required |
| out_fault | output | 1 | Region not permitted (segment fault) |

## Verification
The assertions assume that a requester keeps its request fields stable only within the cycle it is accepted. They relate a result to the inputs sampled on the accepting edge, so they rely on in_valid being driven to a known level after reset. They also assume the consumer drives out_ready to a known level on every edge. The bench drives all inputs at the falling edge and never leaves them unknown once reset is released. It sweeps every region, both privilege bits, partition values that include zero and all ones, and several process values, with random lower address bits. A stall phase holds out_ready low while a second request waits.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

  // Address region selected by the two top effective-address bits.
  typedef enum logic [1:0] {
    RGN_LOW      = 2'd0,  // application space (own or host)
    RGN_GST_USER = 2'd1,  // guest application space, reached from hypervisor
    RGN_GST_KERN = 2'd2,  // guest kernel space, reached from hypervisor
    RGN_HIGH     = 2'd3   // kernel space, process 0
  } region_e;

endpackage

// File: rtl/qsel_decode.sv
module qsel_decode
  import qsel_pkg::*;
#(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic [1:0]        rgn_bits,
  input  logic              hv,
  input  logic              pr,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  output logic [LPID_W-1:0] eff_lpid,
  output logic [PID_W-1:0]  eff_pid,
  output logic              stage2,
  output logic              fault
);

  region_e rgn;
  logic    lpid_nz;

  assign rgn     = region_e'(rgn_bits);
  assign lpid_nz = |lpid_reg;

  always_comb begin
    eff_lpid = '0;
    eff_pid  = '0;
    stage2   = 1'b0;
    fault    = 1'b0;
    if (hv) begin
      unique case (rgn)
        RGN_LOW: begin
          eff_pid = pid_reg;
        end
        RGN_HIGH: begin
          eff_pid = '0;
        end
        RGN_GST_USER: begin
          if (pr) begin
            fault = 1'b1;
          end else begin
            eff_lpid = lpid_reg;
            eff_pid  = pid_reg;
            stage2   = lpid_nz;
          end
        end
        RGN_GST_KERN: begin
          if (pr) begin
            fault = 1'b1;
          end else begin
            eff_lpid = lpid_reg;
            stage2   = lpid_nz;
          end
        end
        default: fault = 1'b1;
      endcase
    end else begin
      unique case (rgn)
        RGN_LOW: begin
          eff_lpid = lpid_reg;
          eff_pid  = pid_reg;
          stage2   = 1'b1;
        end
        RGN_HIGH: begin
          eff_lpid = lpid_reg;
          stage2   = 1'b1;
        end
        default: fault = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/qsel_outreg.sv
module qsel_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/qsel_ctx_select.sv
module qsel_ctx_select #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [EA_W-1:0]   in_ea,
  input  logic              in_hv,
  input  logic              in_pr,
  input  logic [LPID_W-1:0] in_lpid,
  input  logic [PID_W-1:0]  in_pid,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LPID_W-1:0] out_lpid,
  output logic [PID_W-1:0]  out_pid,
  output logic              out_stage2,
  output logic              out_fault
);

  localparam int CTX_W = LPID_W + PID_W + 2;

  logic [1:0]        rgn_bits;
  logic [LPID_W-1:0] d_lpid;
  logic [PID_W-1:0]  d_pid;
  logic              d_stage2;
  logic              d_fault;
  logic [CTX_W-1:0]  d_ctx;
  logic [CTX_W-1:0]  q_ctx;
  logic              unused_low_ea;

  assign rgn_bits      = in_ea[EA_W-1 -: 2];
  assign unused_low_ea = ^in_ea[EA_W-3:0];

  qsel_decode #(
    .LPID_W(LPID_W),
    .PID_W (PID_W)
  ) u_decode (
    .rgn_bits(rgn_bits),
    .hv      (in_hv),
    .pr      (in_pr),
    .lpid_reg(in_lpid),
    .pid_reg (in_pid),
    .eff_lpid(d_lpid),
    .eff_pid (d_pid),
    .stage2  (d_stage2),
    .fault   (d_fault)
  );

  assign d_ctx = {d_fault, d_stage2, d_lpid, d_pid};

  qsel_outreg #(
    .W(CTX_W)
  ) u_outreg (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (d_ctx),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (q_ctx)
  );

  assign {out_fault, out_stage2, out_lpid, out_pid} = q_ctx;

endmodule

// File: rtl/qsel_ctx_select_chk.sv
module qsel_ctx_select_chk #(
  parameter int EA_W   = 64,
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [EA_W-1:0]   in_ea,
  input logic              in_hv,
  input logic              in_pr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [LPID_W-1:0] out_lpid,
  input logic [PID_W-1:0]  out_pid,
  input logic              out_stage2,
  input logic              out_fault
);

  logic [1:0] rgn;
  assign rgn = in_ea[EA_W-1 -: 2];

  // R2 / R3: host regions run under partition 0 with a single stage
  p_host_part0_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_hv && (rgn == 2'd0 || rgn == 2'd3))
      |=> (out_lpid == '0 && !out_stage2 && !out_fault));

  // R3: region 3 always uses process 0
  p_kern_pid0_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && rgn == 2'd3) |=> (out_pid == '0 && !out_fault));

  // R6: guest accesses always need the second stage
  p_guest_stage2_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_hv && (rgn == 2'd0 || rgn == 2'd3))
      |=> (out_stage2 && !out_fault));

  // R7: middle regions fault outside privileged hypervisor state
  p_mid_fault_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (!in_hv || in_pr) && (rgn == 2'd1 || rgn == 2'd2))
      |=> out_fault);

  // R7: a fault carries an empty context
  p_fault_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_fault) |-> (out_lpid == '0 && out_pid == '0 && !out_stage2));

  // R8: accepted request shows up on the next cycle
  p_accept_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8: an empty output stage accepts
  p_empty_ready_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R9: a stalled result holds
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_lpid) && $stable(out_pid)
                                   && $stable(out_stage2) && $stable(out_fault)));

  // R9: drained with no new request
  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind qsel_ctx_select qsel_ctx_select_chk #(
  .EA_W  (EA_W),
  .LPID_W(LPID_W),
  .PID_W (PID_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ea     (in_ea),
  .in_hv     (in_hv),
  .in_pr     (in_pr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_lpid  (out_lpid),
  .out_pid   (out_pid),
  .out_stage2(out_stage2),
  .out_fault (out_fault)
);

// File: tb/test_qsel_ctx_select.sv
module test_qsel_ctx_select;

  localparam int CLK_P  = 10;
  localparam int EA_W   = 64;
  localparam int LPID_W = 12;
  localparam int PID_W  = 20;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic              in_ready;
  logic [EA_W-1:0]   in_ea;
  logic              in_hv;
  logic              in_pr;
  logic [LPID_W-1:0] in_lpid;
  logic [PID_W-1:0]  in_pid;
  logic              out_valid;
  logic              out_ready;
  logic [LPID_W-1:0] out_lpid;
  logic [PID_W-1:0]  out_pid;
  logic              out_stage2;
  logic              out_fault;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  qsel_ctx_select #(
    .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W)
  ) i_qsel_ctx_select (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_ea(in_ea),
    .in_hv(in_hv), .in_pr(in_pr), .in_lpid(in_lpid), .in_pid(in_pid),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_lpid(out_lpid), .out_pid(out_pid),
    .out_stage2(out_stage2), .out_fault(out_fault)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected context from the requirement text.
  task automatic expect_ctx(input int q, input bit hv, input bit pr,
                            input logic [LPID_W-1:0] l, input logic [PID_W-1:0] p,
                            output logic [LPID_W-1:0] el, output logic [PID_W-1:0] ep,
                            output bit es2, output bit ef, output string req);
    el = '0; ep = '0; es2 = 0; ef = 0;
    if ((q == 1 || q == 2) && (!hv || pr)) begin
      ef = 1; req = "R7";
    end else if (hv) begin
      if (q == 0)      begin ep = p; req = "R2"; end
      else if (q == 3) begin ep = '0; req = "R3"; end
      else begin
        el = l; es2 = (l != 0);
        ep = (q == 1) ? p : '0;
        req = (q == 1) ? "R4" : "R5";
      end
    end else begin
      el = l; es2 = 1;
      ep = (q == 0) ? p : '0;
      req = "R6";
    end
  endtask

  task automatic run_one(input int q, input bit hv, input bit pr,
                         input logic [LPID_W-1:0] l, input logic [PID_W-1:0] p,
                         input logic [EA_W-3:0] low, input string tag_override);
    logic [LPID_W-1:0] el;
    logic [PID_W-1:0]  ep;
    bit es2, ef;
    string req;
    expect_ctx(q, hv, pr, l, p, el, ep, es2, ef, req);
    if (tag_override != "") req = tag_override;
    @(negedge clk);
    in_valid  = 1'b1;
    in_ea     = {2'(q), low};
    in_hv     = hv;
    in_pr     = pr;
    in_lpid   = l;
    in_pid    = p;
    out_ready = 1'b1;
    #1;
    check(in_ready === 1'b1, "R8", "in_ready at offer", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R8", "out_valid after accept", 64'(out_valid), 64'd1);
    check(out_lpid === el, req, "out_lpid", 64'(out_lpid), 64'(el));
    check(out_pid === ep, req, "out_pid", 64'(out_pid), 64'(ep));
    check(out_stage2 === es2, req, "out_stage2", 64'(out_stage2), 64'(es2));
    check(out_fault === ef, req, "out_fault", 64'(out_fault), 64'(ef));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_ea = '0; in_hv = 1'b0; in_pr = 1'b0;
    in_lpid = '0; in_pid = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    check(out_valid === 1'b0, "R10", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

    // Full sweep over region, privilege, partition and process values.
    for (int q = 0; q < 4; q++)
      for (int hv = 0; hv < 2; hv++)
        for (int pr = 0; pr < 2; pr++)
          for (int li = 0; li < 4; li++)
            for (int pi = 0; pi < 3; pi++) begin
              logic [LPID_W-1:0] l;
              logic [PID_W-1:0]  p;
              l = (li == 0) ? '0 : (li == 1) ? LPID_W'(1) :
                  (li == 2) ? LPID_W'('h5a3) : '1;
              p = (pi == 0) ? '0 : (pi == 1) ? PID_W'('h1234) : '1;
              run_one(q, hv[0], pr[0], l, p,
                      (EA_W-2)'({$urandom(), $urandom()}), "");
            end

    // R1: extreme lower address bits do not change the result
    for (int q = 0; q < 4; q++) begin
      run_one(q, 1'b1, 1'b0, LPID_W'('h3c), PID_W'('h777), '0, "R1");
      run_one(q, 1'b1, 1'b0, LPID_W'('h3c), PID_W'('h777), '1, "R1");
      run_one(q, 1'b0, 1'b0, LPID_W'('h3c), PID_W'('h777), '1, "R1");
    end

    // R9: stall. Request A accepted, consumer stalls, request B waits.
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_ea     = {2'd1, 62'h0};
    in_hv     = 1'b1; in_pr = 1'b0;
    in_lpid   = LPID_W'('h0a1); in_pid = PID_W'('h0b2);
    @(negedge clk);
    in_ea   = {2'd3, 62'h5};
    in_hv   = 1'b0;
    in_lpid = LPID_W'('h0c3); in_pid = PID_W'('h0d4);
    #1;
    check(in_ready === 1'b0, "R9", "in_ready while stalled", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1, "R9", "valid held", 64'(out_valid), 64'd1);
      check(out_lpid === LPID_W'('h0a1), "R9", "lpid held", 64'(out_lpid), 64'h0a1);
      check(out_pid === PID_W'('h0b2), "R9", "pid held", 64'(out_pid), 64'h0b2);
      check(out_stage2 === 1'b1, "R9", "stage2 held", 64'(out_stage2), 64'd1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    // B was accepted on the edge that drained A
    check(out_valid === 1'b1, "R9", "B valid", 64'(out_valid), 64'd1);
    check(out_lpid === LPID_W'('h0c3), "R9", "B lpid", 64'(out_lpid), 64'h0c3);
    check(out_pid === PID_W'('h0), "R9", "B pid", 64'(out_pid), 64'h0);
    check(out_stage2 === 1'b1, "R9", "B stage2", 64'(out_stage2), 64'd1);
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "valid drops after drain", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R8", "ready when empty", 64'(in_ready), 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule